// File: doc/BRIEF.md
# Triple Half-Bridge Serial Control Port

This block is the 16-bit serial slave through which a host commands a driver for three half-bridges. The host pulls chip select low, clocks in a control word and at the same time clocks out a status word, both least significant bit first. Nothing changes on the control outputs until chip select goes high again. At that point a complete 16-bit word drives three low-side and three high-side switch enables and an overcurrent-shutdown enable, and it can clear the latched fault flags.

The serial pins are sampled by the block's system clock, so each host edge is detected one system clock after it arrives. The status word holds a live temperature pre-warning bit, six live per-switch status bits and three sticky fault flags: short-circuit, open-load and power-supply fault. One-cycle pulses from the fault detectors set these flags. The block also blocks shoot-through: a word that asks for both sides of the same half-bridge turns that half-bridge fully off.

Top module: `hb_serial_ctrl`

## Requirements
- R1: After reset all six switch enables are 0, `ocs_en` is 1, `sdo_oe` is 0 and all three fault flags read 0.
- R2: `sdo_oe` is 1 while a transfer is active. It goes high one clock after `cs_n` is seen low and goes low one clock after `cs_n` is seen high.
- R3: Serial input is taken on each falling `sck` edge with `cs_n` low, bit 0 first. When `cs_n` rises after exactly 16 falling edges, the word is applied: bit 1 drives `ls_on[0]`, bit 2 `hs_on[0]`, bit 3 `ls_on[1]`, bit 4 `hs_on[1]`, bit 5 `ls_on[2]`, bit 6 `hs_on[2]` (1 = on), and bit 13 drives `ocs_en`.
- R4: Control bits 7 to 12, 14 and 15 have no effect on any output.
- R5: If a word sets both the low-side bit and the high-side bit of one half-bridge, both enables of that half-bridge become 0. The other half-bridges follow their own bits.
- R6: A transfer that ends with a falling-edge count other than 16 changes neither the control outputs nor the fault flags.
- R7: The status word is captured when `cs_n` falls. Its layout is: bit 0 `temp_warn`, bits 1 to 6 `sw_stat[5:0]`, bits 7 to 12 zero, bit 13 short-circuit flag, bit 14 open-load flag, bit 15 supply flag. It is sent LSB first on `sdo`. Bit 0 is valid before the first rising `sck` edge. Each later rising edge moves to the next bit, and `sdo` holds its value between rising edges.
- R8: A one-cycle pulse on `scd_pulse`, `opl_pulse` or `psf_pulse` sets its flag, and the flag stays set.
- R9: An applied word with bit 0 set clears all three fault flags.
- R10: A fault pulse in the same clock as an applied clear leaves that flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out (0 when not enabled) |
| sdo_oe | output | 1 | Output enable for the serial data out pad |
| ls_on | output | 3 | Low-side switch enables, one per half-bridge |
| hs_on | output | 3 | High-side switch enables, one per half-bridge |
| ocs_en | output | 1 | Overcurrent shutdown enable |
| temp_warn | input | 1 | Live temperature pre-warning |
| sw_stat | input | 6 | Live switch status bits, in the same order as the switch enables |
| scd_pulse | input | 1 | Short-circuit detect pulse |
| opl_pulse | input | 1 | Open-load detect pulse |
| psf_pulse | input | 1 | Supply fault detect pulse |

## Verification
Two functions can fall in the same system-clock cycle: a fault pulse that sets a flag, and a status-reset command applied at the rising edge of chip select. The bench raises `cs_n` and a chosen fault pulse on the same clock, so both reach the flag logic at one edge. It then reads the next status word to confirm that the pulsed flag survived and the other flags were cleared. The full sweep of the six switch bits, with unused bits scrambled, also covers shoot-through blocking and the status layout on every transfer.

// File: rtl/hb_serial_ctrl.sv
module hb_serial_ctrl #(
  parameter int WORD_W = 16,
  parameter int NUM_BR = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              sdi,
  output logic              sdo,
  output logic              sdo_oe,
  output logic [NUM_BR-1:0] ls_on,
  output logic [NUM_BR-1:0] hs_on,
  output logic              ocs_en,
  input  logic              temp_warn,
  input  logic [2*NUM_BR-1:0] sw_stat,
  input  logic              scd_pulse,
  input  logic              opl_pulse,
  input  logic              psf_pulse
);
  localparam int CW     = $clog2(WORD_W + 2);
  localparam int SRR_B  = 0;
  localparam int SW_B   = 1;
  localparam int OCS_B  = 13;
  localparam int FLG_B  = 13;
  localparam logic [CW-1:0] FULL = CW'(WORD_W);
  localparam logic [CW-1:0] OVER = CW'(WORD_W + 1);

  logic              cs_q, sck_q;
  logic [WORD_W-1:0] rx_sr, tx_sr, stat_word;
  logic [CW-1:0]     bit_cnt;
  logic [2:0]        flags;
  logic [NUM_BR-1:0] ls_nx, hs_nx;

  wire active   = ~cs_q & ~cs_n;
  wire cs_fall  = cs_q & ~cs_n;
  wire cs_rise  = ~cs_q & cs_n;
  wire sck_fall = active & sck_q & ~sck;
  wire sck_rise = active & ~sck_q & sck;
  wire apply    = cs_rise & (bit_cnt == FULL);
  wire clr      = apply & rx_sr[SRR_B];

  assign sdo_oe = ~cs_q;
  assign sdo    = sdo_oe & tx_sr[0];

  always_comb begin
    stat_word = '0;
    stat_word[0] = temp_warn;
    stat_word[SW_B +: 2*NUM_BR] = sw_stat;
    stat_word[FLG_B +: 3] = flags;
  end

  for (genvar b = 0; b < NUM_BR; b++) begin : g_br
    wire lo_req = rx_sr[SW_B + 2*b];
    wire hi_req = rx_sr[SW_B + 2*b + 1];
    assign ls_nx[b] = lo_req & ~hi_req;
    assign hs_nx[b] = hi_req & ~lo_req;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cs_q    <= 1'b1;
      sck_q   <= 1'b0;
      rx_sr   <= '0;
      tx_sr   <= '0;
      bit_cnt <= '0;
      flags   <= '0;
      ls_on   <= '0;
      hs_on   <= '0;
      ocs_en  <= 1'b1;
    end else begin
      cs_q  <= cs_n;
      sck_q <= sck;
      flags <= {psf_pulse, opl_pulse, scd_pulse} | (flags & ~{3{clr}});
      if (cs_fall) begin
        bit_cnt <= '0;
        tx_sr   <= stat_word;
      end else begin
        if (sck_fall) begin
          rx_sr <= {sdi, rx_sr[WORD_W-1:1]};
          if (bit_cnt != OVER) bit_cnt <= bit_cnt + 1'b1;
        end
        if (sck_rise && bit_cnt != '0) tx_sr <= {1'b0, tx_sr[WORD_W-1:1]};
      end
      if (apply) begin
        ls_on  <= ls_nx;
        hs_on  <= hs_nx;
        ocs_en <= rx_sr[OCS_B];
      end
    end
  end
endmodule

// File: rtl/hb_serial_ctrl_chk.sv
module hb_serial_ctrl_chk #(
  parameter int NUM_BR = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n,
  input logic              sck,
  input logic              sdo,
  input logic              sdo_oe,
  input logic [NUM_BR-1:0] ls_on,
  input logic [NUM_BR-1:0] hs_on,
  input logic              ocs_en
);
  a_r2_oe_off: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && $past(cs_n)) |-> !sdo_oe);

  a_r2_oe_on: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !$past(cs_n)) |-> sdo_oe);

  a_r5_no_shoot: assert property (@(posedge clk) disable iff (!rst_n)
    (ls_on & hs_on) == '0);

  a_r6_apply_on_release: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({ls_on, hs_on, ocs_en}) |-> ($past(cs_n) && !$past(cs_n, 2)));

  a_r7_sdo_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (sdo_oe && $past(sdo_oe) && !$stable(sdo)) |-> ($past(sck) && !$past(sck, 2)));
endmodule

bind hb_serial_ctrl hb_serial_ctrl_chk #(.NUM_BR(NUM_BR)) chk_i (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdo(sdo),
  .sdo_oe(sdo_oe), .ls_on(ls_on), .hs_on(hs_on), .ocs_en(ocs_en)
);

// File: tb/hb_serial_ctrl_tb_top.sv
module hb_serial_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0, cs_n = 1'b1, sck = 1'b0, sdi = 1'b0;
  logic sdo, sdo_oe, ocs_en, temp_warn = 1'b0;
  logic [2:0] ls_on, hs_on;
  logic [5:0] sw_stat = '0;
  logic scd_pulse = 1'b0, opl_pulse = 1'b0, psf_pulse = 1'b0;

  int checks = 0, errors = 0;
  logic [2:0] m_ls = '0, m_hs = '0, m_flags = '0;
  logic       m_ocs = 1'b1;
  logic [15:0] rd;

  always #2 clk = ~clk;

  hb_serial_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdi(sdi),
    .sdo(sdo), .sdo_oe(sdo_oe), .ls_on(ls_on), .hs_on(hs_on), .ocs_en(ocs_en),
    .temp_warn(temp_warn), .sw_stat(sw_stat),
    .scd_pulse(scd_pulse), .opl_pulse(opl_pulse), .psf_pulse(psf_pulse)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_word();
    return {m_flags, 6'b0, sw_stat, temp_warn};
  endfunction

  task automatic model(input logic [15:0] din, input int nbits, input logic [2:0] rel);
    if (nbits == 16) begin
      m_flags = rel | (m_flags & ~{3{din[0]}});
      for (int b = 0; b < 3; b++) begin
        m_ls[b] = din[1+2*b] & ~din[2+2*b];
        m_hs[b] = din[2+2*b] & ~din[1+2*b];
      end
      m_ocs = din[13];
    end else m_flags = rel | m_flags;
  endtask

  task automatic xfer(input logic [15:0] din, input int nbits, input logic [2:0] rel,
                      output logic [15:0] dout);
    dout = '0;
    @(negedge clk) cs_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R2 oe active", sdo_oe, 1);
    for (int k = 0; k < nbits; k++) begin
      sdi = din[k % 16];
      sck = 1'b1;
      repeat (3) @(negedge clk);
      if (k < 16) dout[k] = sdo;
      sck = 1'b0;
      repeat (3) @(negedge clk);
    end
    cs_n = 1'b1;
    {psf_pulse, opl_pulse, scd_pulse} = rel;
    @(negedge clk) {psf_pulse, opl_pulse, scd_pulse} = 3'b0;
    repeat (2) @(negedge clk);
    check("R2 oe idle", sdo_oe, 0);
    model(din, nbits, rel);
  endtask

  task automatic pulse(input logic [2:0] m);
    @(negedge clk) {psf_pulse, opl_pulse, scd_pulse} = m;
    @(negedge clk) {psf_pulse, opl_pulse, scd_pulse} = 3'b0;
    m_flags = m_flags | m;
  endtask

  task automatic check_outs(input string req);
    check(req, {ls_on, hs_on, ocs_en}, {m_ls, m_hs, m_ocs});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] w, e;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 switches", {ls_on, hs_on}, 6'b0);
    check("R1 ocs", ocs_en, 1);
    check("R1 oe", sdo_oe, 0);
    e = exp_word();
    xfer(16'h2000, 16, 3'b0, rd);
    check("R1 flags clear", rd[15:13], 3'b0);
    check("R7 status word", rd, e);

    // R3 R5 R7 sweep over all switch-bit patterns, unused bits scrambled (R4)
    for (int i = 0; i < 64; i++) begin
      logic [5:0] iv;
      logic [5:0] junk;
      iv = 6'(i);
      junk = 6'(i * 7 + 3);
      sw_stat = iv ^ 6'h2b;
      temp_warn = iv[2];
      w = {iv[1:0], iv[0] ^ iv[3], junk, iv, 1'b0};
      e = exp_word();
      xfer(w, 16, 3'b0, rd);
      check("R7 status layout", rd, e);
      check_outs("R3 R5 apply");
    end

    // R4 same meaningful bits, unused bits flipped both ways
    w = 16'h200a;
    xfer(w, 16, 3'b0, rd);
    check_outs("R4 base");
    xfer(w | 16'hdf80, 16, 3'b0, rd);
    check_outs("R4 unused set");
    xfer(w & ~16'hdf80, 16, 3'b0, rd);
    check_outs("R4 unused clear");

    // R8 sticky flags
    pulse(3'b001);
    repeat (4) @(negedge clk);
    e = exp_word();
    xfer(16'h2000, 16, 3'b0, rd);
    check("R8 scd sticky", rd, e);
    pulse(3'b110);
    e = exp_word();
    xfer(16'h2000, 16, 3'b0, rd);
    check("R8 opl psf sticky", rd[15:13], 3'b111);
    check("R7 status", rd, e);

    // R6 wrong length transfers discarded
    xfer(16'h0055, 15, 3'b0, rd);
    check_outs("R6 short");
    xfer(16'h0055, 17, 3'b0, rd);
    check_outs("R6 long");
    xfer(16'h0055, 32, 3'b0, rd);
    check_outs("R6 double");
    xfer(16'h2000, 16, 3'b0, rd);
    check("R6 flags kept", rd[15:13], 3'b111);

    // R9 status reset
    xfer(16'h2001, 16, 3'b0, rd);
    e = exp_word();
    xfer(16'h2000, 16, 3'b0, rd);
    check("R9 flags cleared", rd[15:13], 3'b000);
    check("R9 word", rd, e);

    // R10 set beats clear in the same cycle
    pulse(3'b111);
    xfer(16'h2001, 16, 3'b010, rd);
    check("R10 model", m_flags, 3'b010);
    xfer(16'h0000, 16, 3'b0, rd);
    check("R10 opl survives", rd[15:13], 3'b010);
    check_outs("R3 ocs off");
    pulse(3'b101);
    xfer(16'h0001, 16, 3'b101, rd);
    xfer(16'h2000, 16, 3'b0, rd);
    check("R10 scd psf survive", rd[15:13], 3'b101);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule